// File: doc/BRIEF.md
# Trigger Pipeline Cell Bookkeeper

This block keeps track of which cells of a front-end analog sampling pipeline hold events that the first-level trigger has accepted. A free-running crossing counter points into the circular pipeline, one crossing per clock. When an accept arrives, the block works out which cell holds the triggered crossing. It does so by stepping back a programmable trigger latency. It stores that cell in one of a small number of tracking slots and emits a one-cycle digitize-and-readout request that names the cell and the slot.

Downstream participants report success per slot. These participants are the readout controllers and the data buffers, and each one is a bit of a status mask. A tracked cell stays protected from overwrite until every participant has reported. Even then it is freed only while the crossing counter lies inside a programmable beam-gap window. Each release pulses a completion status toward the trigger supervisor. An internal emulator can replace the external accept, so the block can be exercised standalone.

Top module: `trig_cell_keeper`

## Requirements
- R1: After reset the crossing index is 0; it advances by one every clock and wraps from DEPTH-1 (41) to 0.
- R2: An accept that finds a free slot marks cell (index - lat) mod DEPTH in the lowest-numbered free slot. One cycle later `rd_req` pulses with that cell on `rd_cell` and the slot number on `rd_slot`. `lat` must be below DEPTH.
- R3: At most SLOTS (4) cells are tracked at once. An accept while all slots are in use marks nothing and issues no request; instead `ovf` pulses one cycle later.
- R4: A status pulse (`ok_valid`) ORs `ok_mask` into the success bits of slot `ok_slot`. Bit k stands for participant k. A pulse aimed at a slot that is not in use has no effect.
- R5: A slot whose success bits are all set is released only in a cycle where the crossing index lies in the gap window. At most one slot is released per cycle, the lowest-numbered one first. One cycle after the release, `done` pulses with the released cell and slot.
- R6: The gap window includes both `gap_lo` and `gap_hi`. When `gap_lo` > `gap_hi`, it wraps through DEPTH-1 and 0.
- R7: With `emu_en` high the external accept is ignored. The emulator then fires an accept once every `emu_period` clocks, and never when `emu_period` is 0. With `emu_en` low, only `ext_accept` counts.
- R8: `hold_map` has bit c set exactly when some in-use slot tracks cell c. `busy` is high exactly when all slots are in use.
- R9: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beam crossing per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_accept | input | 1 | External first-level accept |
| emu_en | input | 1 | Select internal emulator as accept source |
| emu_period | input | EW (8) | Emulator firing period in clocks, 0 = off |
| lat | input | CW (6) | Trigger latency in crossings |
| gap_lo | input | CW (6) | First crossing index of gap window |
| gap_hi | input | CW (6) | Last crossing index of gap window |
| ok_valid | input | 1 | Success status strobe |
| ok_slot | input | SW (2) | Slot the status applies to |
| ok_mask | input | NCH (4) | Participants reporting success |
| xing | output | CW (6) | Current crossing / pipeline write index |
| rd_req | output | 1 | Digitize-and-readout request pulse |
| rd_cell | output | CW (6) | Cell to digitize |
| rd_slot | output | SW (2) | Slot tracking that cell |
| ovf | output | 1 | Accept dropped, all slots busy |
| busy | output | 1 | All slots in use |
| hold_map | output | DEPTH (42) | Cells protected from overwrite |
| done | output | 1 | Completion status pulse to trigger supervisor |
| done_cell | output | CW (6) | Cell released |
| done_slot | output | SW (2) | Slot released |

## Verification
Several rules are checked by the assertions on every cycle. They cover the counter stepping and wrap, that every request names a cell already shown as held, that a drop only happens when all slots were busy and never together with a request, that every completion falls right after an in-gap crossing, and that the external accept is shut out while the emulator runs at period zero. Other behaviour can only be shown by the bench's scenarios. This includes the latency arithmetic across the wrap and the choice of lowest slot for both marking and release. It also covers status aimed at idle slots being dropped, wrapped gap windows, and the exact emulator cadence. A behavioural model compares every output each clock under directed and random traffic to catch these.

// File: rtl/trig_cell_keeper.sv
module trig_cell_keeper #(
  parameter int DEPTH = 42,
  parameter int SLOTS = 4,
  parameter int NCH   = 4,
  parameter int EW    = 8,
  localparam int CW   = $clog2(DEPTH),
  localparam int SW   = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_accept,
  input  logic             emu_en,
  input  logic [EW-1:0]    emu_period,
  input  logic [CW-1:0]    lat,
  input  logic [CW-1:0]    gap_lo,
  input  logic [CW-1:0]    gap_hi,
  input  logic             ok_valid,
  input  logic [SW-1:0]    ok_slot,
  input  logic [NCH-1:0]   ok_mask,
  output logic [CW-1:0]    xing,
  output logic             rd_req,
  output logic [CW-1:0]    rd_cell,
  output logic [SW-1:0]    rd_slot,
  output logic             ovf,
  output logic             busy,
  output logic [DEPTH-1:0] hold_map,
  output logic             done,
  output logic [CW-1:0]    done_cell,
  output logic [SW-1:0]    done_slot
);

  logic [SLOTS-1:0] used;
  logic [CW-1:0]    cell_q [SLOTS];
  logic [NCH-1:0]   okb    [SLOTS];
  logic [EW-1:0]    ecnt;

  logic          emu_fire, accept, have_free, have_rel, in_gap, take, rel_go;
  logic [SW-1:0] free_idx, rel_idx;
  logic [CW-1:0] acell;

  assign emu_fire = emu_en && (emu_period != '0) && (ecnt >= emu_period - EW'(1));
  assign accept   = emu_en ? emu_fire : ext_accept;
  assign acell    = (xing >= lat) ? (xing - lat) : CW'(xing + CW'(DEPTH) - lat);
  assign in_gap   = (gap_lo <= gap_hi) ? (xing >= gap_lo && xing <= gap_hi)
                                       : (xing >= gap_lo || xing <= gap_hi);
  assign take     = accept && have_free;
  assign rel_go   = have_rel && in_gap;
  assign busy     = &used;

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    have_rel  = 1'b0;
    rel_idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        have_free = 1'b1;
        free_idx  = SW'(i);
      end
      if (used[i] && (&okb[i])) begin
        have_rel = 1'b1;
        rel_idx  = SW'(i);
      end
    end
  end

  always_comb begin
    hold_map = '0;
    for (int i = 0; i < SLOTS; i++)
      if (used[i]) hold_map[cell_q[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xing      <= '0;
      ecnt      <= '0;
      rd_req    <= 1'b0;
      rd_cell   <= '0;
      rd_slot   <= '0;
      ovf       <= 1'b0;
      done      <= 1'b0;
      done_cell <= '0;
      done_slot <= '0;
      used      <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        cell_q[i] <= '0;
        okb[i]    <= '0;
      end
    end else begin
      xing <= (xing == CW'(DEPTH - 1)) ? '0 : xing + CW'(1);

      if (!emu_en || emu_fire)       ecnt <= '0;
      else if (emu_period != '0)     ecnt <= ecnt + EW'(1);

      rd_req <= take;
      if (take) begin
        rd_cell <= acell;
        rd_slot <= free_idx;
      end
      ovf <= accept && !have_free;

      done <= rel_go;
      if (rel_go) begin
        done_cell <= cell_q[rel_idx];
        done_slot <= rel_idx;
      end

      for (int i = 0; i < SLOTS; i++) begin
        if (rel_go && rel_idx == SW'(i)) begin
          used[i] <= 1'b0;
          okb[i]  <= '0;
        end else if (take && free_idx == SW'(i)) begin
          used[i]   <= 1'b1;
          cell_q[i] <= acell;
          okb[i]    <= '0;
        end else if (ok_valid && ok_slot == SW'(i) && used[i]) begin
          okb[i] <= okb[i] | ok_mask;
        end
      end
    end
  end

endmodule

// File: rtl/trig_cell_keeper_chk.sv
module trig_cell_keeper_chk #(
  parameter int DEPTH = 42,
  parameter int SLOTS = 4,
  parameter int NCH   = 4,
  parameter int EW    = 8,
  localparam int CW   = $clog2(DEPTH),
  localparam int SW   = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_accept,
  input logic             emu_en,
  input logic [EW-1:0]    emu_period,
  input logic [CW-1:0]    lat,
  input logic [CW-1:0]    gap_lo,
  input logic [CW-1:0]    gap_hi,
  input logic             ok_valid,
  input logic [SW-1:0]    ok_slot,
  input logic [NCH-1:0]   ok_mask,
  input logic [CW-1:0]    xing,
  input logic             rd_req,
  input logic [CW-1:0]    rd_cell,
  input logic [SW-1:0]    rd_slot,
  input logic             ovf,
  input logic             busy,
  input logic [DEPTH-1:0] hold_map,
  input logic             done,
  input logic [CW-1:0]    done_cell,
  input logic [SW-1:0]    done_slot
);

  logic gap_now;
  assign gap_now = (gap_lo <= gap_hi) ? (xing >= gap_lo && xing <= gap_hi)
                                      : (xing >= gap_lo || xing <= gap_hi);

  p_xing_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xing != CW'(DEPTH - 1)) |=> (xing == $past(xing) + CW'(1)));

  p_xing_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xing == CW'(DEPTH - 1)) |=> (xing == '0));

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> hold_map[rd_cell]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (!rd_req && $past(busy)));

  p_done_in_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gap_now == 1'b0 |=> !done);

  p_emu_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_en && emu_period == '0) |=> (!rd_req && !ovf));

endmodule

bind trig_cell_keeper trig_cell_keeper_chk #(
  .DEPTH(DEPTH), .SLOTS(SLOTS), .NCH(NCH), .EW(EW)
) u_chk (.*);

// File: tb/tb_trig_cell_keeper.sv
module tb_trig_cell_keeper;
  localparam int DEPTH = 42;
  localparam int SLOTS = 4;
  localparam int NCH   = 4;
  localparam int FULL  = (1 << NCH) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_accept = 1'b0, emu_en = 1'b0, ok_valid = 1'b0;
  logic [7:0] emu_period = '0;
  logic [5:0] lat = '0, gap_lo = '0, gap_hi = '0;
  logic [1:0] ok_slot = '0;
  logic [3:0] ok_mask = '0;
  logic [5:0] xing, rd_cell, done_cell;
  logic [1:0] rd_slot, done_slot;
  logic rd_req, ovf, busy, done;
  logic [DEPTH-1:0] hold_map;

  int checks = 0, errors = 0, n_done = 0, n_ovf = 0, n_req = 0;

  trig_cell_keeper dut (.*);

  always #2 clk = ~clk;

  // behavioural reference
  int m_x, m_e, m_rdc, m_rds, m_dc, m_ds;
  bit m_rd, m_ovf, m_done;
  bit m_used [SLOTS];
  int m_cell [SLOTS];
  int m_ok   [SLOTS];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_x = 0; m_e = 0; m_rd = 0; m_ovf = 0; m_done = 0;
      m_rdc = 0; m_rds = 0; m_dc = 0; m_ds = 0;
      foreach (m_used[i]) begin m_used[i] = 0; m_cell[i] = 0; m_ok[i] = 0; end
    end else begin
      bit acc, fire, gap;
      int fr, rl, c;
      fire = emu_en && emu_period != 0 && m_e >= int'(emu_period) - 1;
      acc  = emu_en ? fire : ext_accept;
      fr = -1; rl = -1;
      for (int i = SLOTS - 1; i >= 0; i--) begin
        if (!m_used[i]) fr = i;
        if (m_used[i] && m_ok[i] == FULL) rl = i;
      end
      if (gap_lo <= gap_hi) gap = (m_x >= gap_lo) && (m_x <= gap_hi);
      else                  gap = (m_x >= gap_lo) || (m_x <= gap_hi);
      c = (m_x - int'(lat) + DEPTH) % DEPTH;
      m_rd = acc && fr >= 0;
      m_ovf = acc && fr < 0;
      if (m_rd) begin m_rdc = c; m_rds = fr; end
      m_done = gap && rl >= 0;
      if (m_done) begin m_dc = m_cell[rl]; m_ds = rl; end
      if (ok_valid && m_used[ok_slot] && !(m_done && rl == ok_slot))
        m_ok[ok_slot] = m_ok[ok_slot] | int'(ok_mask);
      if (m_done) begin m_used[rl] = 0; m_ok[rl] = 0; end
      if (m_rd) begin m_used[fr] = 1; m_cell[fr] = c; m_ok[fr] = 0; end
      if (!emu_en || fire) m_e = 0;
      else if (emu_period != 0) m_e = m_e + 1;
      m_x = (m_x == DEPTH - 1) ? 0 : m_x + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [DEPTH-1:0] em;
    int nb;
    if (!rst_n) begin
      chk(xing == 0 && !rd_req && !ovf && !done && !busy && hold_map == 0,
          "R9 reset outputs", int'(xing), 0);
    end else begin
      em = '0; nb = 0;
      foreach (m_used[i]) if (m_used[i]) begin em[m_cell[i]] = 1'b1; nb++; end
      chk(int'(xing) == m_x, "R1 crossing index", int'(xing), m_x);
      chk(rd_req == m_rd, "R2 rd_req", int'(rd_req), int'(m_rd));
      if (m_rd) begin
        chk(int'(rd_cell) == m_rdc, "R2 rd_cell", int'(rd_cell), m_rdc);
        chk(int'(rd_slot) == m_rds, "R2 rd_slot", int'(rd_slot), m_rds);
        n_req++;
      end
      chk(ovf == m_ovf, "R3 ovf", int'(ovf), int'(m_ovf));
      if (m_ovf) n_ovf++;
      chk(done == m_done, "R5 done", int'(done), int'(m_done));
      if (m_done) begin
        chk(int'(done_cell) == m_dc, "R5 done_cell", int'(done_cell), m_dc);
        chk(int'(done_slot) == m_ds, "R4 R5 done_slot", int'(done_slot), m_ds);
        n_done++;
      end
      chk(hold_map == em, "R8 hold_map", $countones(hold_map), $countones(em));
      chk(busy == (nb == SLOTS), "R8 busy", int'(busy), int'(nb == SLOTS));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic accept1;
    ext_accept = 1'b1; step(1); ext_accept = 1'b0;
  endtask

  task automatic status(input int s, input int m);
    ok_valid = 1'b1; ok_slot = 2'(s); ok_mask = 4'(m); step(1); ok_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R2 R4 R5: single trigger, split status, gap at end of turn
    lat = 6'd5; gap_lo = 6'd38; gap_hi = 6'd41;
    step(2); accept1; step(3);
    status(0, 4'b0011);
    status(1, 4'b1111);          // R4 idle slot, must be dropped
    status(0, 4'b1100);
    step(50);
    // R3: fill all slots then overflow
    accept1; accept1; accept1; accept1; accept1; accept1;
    step(2);
    for (int s = 0; s < SLOTS; s++) status(s, FULL);
    step(45);
    // R6: wrapped gap, latency at extremes
    gap_lo = 6'd40; gap_hi = 6'd2; lat = 6'd0;
    accept1; lat = 6'd41; accept1;
    status(1, FULL); status(0, FULL);
    step(45);
    // R7: emulator with external accept held high (ignored)
    emu_en = 1'b1; emu_period = 8'd0; ext_accept = 1'b1; step(20);
    emu_period = 8'd7; lat = 6'd3; gap_lo = 6'd0; gap_hi = 6'd20;
    for (int k = 0; k < 200; k++) begin
      ok_valid = 1'b1; ok_slot = 2'(k % SLOTS); ok_mask = 4'(1 << ((k / 4) % NCH));
      step(1);
    end
    ok_valid = 1'b0; ext_accept = 1'b0; emu_en = 1'b0; step(60);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      ext_accept = ($urandom % 6) == 0;
      ok_valid   = ($urandom % 2) == 0;
      ok_slot    = 2'($urandom);
      ok_mask    = 4'($urandom);
      if (k % 500 == 0) begin
        lat = 6'($urandom % DEPTH);
        gap_lo = 6'($urandom % DEPTH);
        gap_hi = 6'($urandom % DEPTH);
      end
      if (k == 1500) begin emu_en = 1'b1; emu_period = 8'd3; end
      step(1);
    end
    ext_accept = 1'b0; ok_valid = 1'b0; emu_en = 1'b0;
    step(5);
    chk(n_done > 0, "R5 releases seen", n_done, 1);
    chk(n_ovf > 0, "R3 drops seen", n_ovf, 1);
    chk(n_req > 0, "R7 requests seen", n_req, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule